// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 interface. It owns the memory reset pin (active low) and the clock-enable pin, and it drives the first commands the memory sees after power-up. While the system reset is asserted, both pins are held low. When reset is released, the memory reset pin goes high and CKE stays low. The block then waits for software to write a configuration word that selects DDR3 with initialization enabled.

A qualifying write starts a timed CKE-low phase. That phase is measured by a down-counter, the same counter a controller would use for refresh spacing, loaded with a long interval. When the interval has elapsed and the memory clock is reported stable, CKE goes high. On the next cycle one auto-refresh command is issued, and a sticky done flag follows. Mode-register programming, ZQ calibration, leveling and the PHY are handled elsewhere.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While rst_ni is low, mem_rst_no is 0, mem_cke_o is 0, cmd_o is DESELECT (3'b000) and init_done_o is 0.
- R2: On the first clock edge after rst_ni rises, mem_rst_no becomes 1 and cmd_o becomes NOP (3'b001), with mem_cke_o still 0.
- R3: A write with cfg_we_i high starts the sequence only when cfg_wdata_i[2:0] equals 3 and cfg_wdata_i[3] is 0. Without such a write, mem_rst_no stays 1, mem_cke_o stays 0 and cmd_o stays NOP for as long as needed.
- R4: The following writes are ignored, leaving mem_cke_o, cmd_o and init_done_o unchanged:
  - a write with any other type value;
  - a write with bit 3 set;
  - any write after the sequence has started.
- R5: mem_cke_o rises no earlier than CKE_LOW_US*CYC_PER_US clock edges after the triggering edge. If clk_stable_i is high, it rises exactly at that edge.
- R6: If clk_stable_i is low when the interval expires, mem_cke_o stays low. It rises on the first edge at which clk_stable_i is sampled high.
- R7: One edge after mem_cke_o rises, cmd_o shows REFRESH (3'b010) for exactly one cycle. Before and after that cycle, cmd_o is NOP.
- R8: init_done_o rises one edge after the REFRESH cycle and stays high until reset.
- R9: Once high, mem_rst_no and mem_cke_o stay high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 4 | Write data: [2:0] memory type, [3] init disable |
| clk_stable_i | input | 1 | Memory clock running and stable |
| mem_rst_no | output | 1 | Memory reset pin, active low |
| mem_cke_o | output | 1 | Memory clock enable |
| cmd_o | output | 3 | Command: 000 DESELECT, 001 NOP, 010 REFRESH |
| init_done_o | output | 1 | Power-up sequence complete |

## Verification
The trigger is tried with three kinds of writes: writes of the wrong type, writes of the right type with the disable bit set, and random writes during and after the sequence. Passing these shows that only the single legal encoding in the idle phase starts the timer. Runs with clk_stable_i held high separate an exact N-cycle CKE rise from an off-by-one count. Runs with clk_stable_i low around expiry show that the stable gate, not the timer alone, releases CKE. Randomized clock-stable patterns then confirm that the refresh and done flag follow the actual CKE edge, not the timer expiry.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL = 3'b000,
    CMD_NOP   = 3'b001,
    CMD_REF   = 3'b010
  } cmd_e;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_WAIT_CFG,
    ST_CKE_LOW,
    ST_CKE_ON,
    ST_REF,
    ST_DONE
  } seq_st_e;

  localparam int unsigned KIND_W    = 3;
  localparam int unsigned KIND_DDR3 = 3;
endpackage

// File: rtl/ddr3_cfg_decode.sv
module ddr3_cfg_decode
  import ddr3_pwrup_pkg::*;
#(
  parameter int unsigned CFG_W   = 4,
  parameter int unsigned DIS_BIT = 3
) (
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             armed_i,
  output logic             start_o
);
  logic kind_ok;
  logic dis;

  assign kind_ok = (wdata_i[KIND_W-1:0] == KIND_W'(KIND_DDR3));
  assign dis     = wdata_i[DIS_BIT];
  assign start_o = we_i && armed_i && kind_ok && !dis;
endmodule

// File: rtl/ddr3_ref_timer.sv
module ddr3_ref_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '1;
    else if (load_i)              cnt_q <= load_val_i;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // saturates at zero instead of wrapping
  p_hold_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ddr3_pwrup_fsm.sv
module ddr3_pwrup_fsm
  import ddr3_pwrup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       expired_i,
  input  logic       clk_stable_i,
  output logic       armed_o,
  output logic       tmr_run_o,
  output logic       mem_rst_no,
  output logic       mem_cke_o,
  output logic [2:0] cmd_o,
  output logic       init_done_o
);
  seq_st_e st_q, st_d;
  logic    rst_n_q, cke_q, done_q;
  cmd_e    cmd_q, cmd_d;

  always_comb begin
    st_d  = st_q;
    cmd_d = cmd_q;
    unique case (st_q)
      ST_RESET:    begin st_d = ST_WAIT_CFG; cmd_d = CMD_NOP; end
      ST_WAIT_CFG: if (start_i) st_d = ST_CKE_LOW;
      ST_CKE_LOW:  if (expired_i && clk_stable_i) st_d = ST_CKE_ON;
      ST_CKE_ON:   begin st_d = ST_REF;  cmd_d = CMD_REF; end
      ST_REF:      begin st_d = ST_DONE; cmd_d = CMD_NOP; end
      ST_DONE:     st_d = ST_DONE;
      default:     st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RESET;
      cmd_q   <= CMD_DESEL;
      rst_n_q <= 1'b0;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      if (st_q == ST_RESET) rst_n_q <= 1'b1;
      if (st_q == ST_CKE_LOW && st_d == ST_CKE_ON) cke_q <= 1'b1;
      if (st_q == ST_REF) done_q <= 1'b1;
    end
  end

  assign armed_o     = (st_q == ST_WAIT_CFG);
  assign tmr_run_o   = (st_q == ST_CKE_LOW);
  assign mem_rst_no  = rst_n_q;
  assign mem_cke_o   = cke_q;
  assign cmd_o       = cmd_q;
  assign init_done_o = done_q;

  p_cke_after_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_q |-> rst_n_q);
  p_cke_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_q |=> cke_q);
  p_idle_cke_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_CFG) |-> !cke_q);
  p_no_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_WAIT_CFG && st_q != ST_RESET) |=> (st_q != ST_WAIT_CFG));
  p_cke_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_q) |-> ($past(clk_stable_i) && $past(expired_i)));
  p_ref_after_cke_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_REF) |-> (cke_q && $past(cke_q)));
  p_ref_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_REF) |=> (cmd_q == CMD_NOP));
  p_done_after_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(cmd_q == CMD_REF));
  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 800,
  parameter int unsigned CKE_LOW_US = 500,
  parameter int unsigned CFG_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             clk_stable_i,
  output logic             mem_rst_no,
  output logic             mem_cke_o,
  output logic [2:0]       cmd_o,
  output logic             init_done_o
);
  localparam int unsigned CKE_LOW_CYC = CKE_LOW_US * CYC_PER_US;
  localparam int unsigned TMR_W       = (CKE_LOW_CYC > 2) ? $clog2(CKE_LOW_CYC) : 1;
  localparam logic [TMR_W-1:0] CKE_LOAD = TMR_W'(CKE_LOW_CYC - 1);

  logic start, armed, expired, tmr_run;

  ddr3_cfg_decode #(.CFG_W(CFG_W), .DIS_BIT(KIND_W)) u_dec (
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .armed_i (armed),
    .start_o (start)
  );

  ddr3_ref_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (CKE_LOAD),
    .run_i      (tmr_run),
    .expired_o  (expired)
  );

  ddr3_pwrup_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .expired_i    (expired),
    .clk_stable_i (clk_stable_i),
    .armed_o      (armed),
    .tmr_run_o    (tmr_run),
    .mem_rst_no   (mem_rst_no),
    .mem_cke_o    (mem_cke_o),
    .cmd_o        (cmd_o),
    .init_done_o  (init_done_o)
  );
endmodule

// File: tb/ddr3_pwrup_seq_tb.sv
module ddr3_pwrup_seq_tb_top;
  localparam int unsigned CPU = 4;
  localparam int unsigned CLU = 5;
  localparam int N = CPU * CLU;
  localparam logic [2:0] C_DES = 3'b000, C_NOP = 3'b001, C_REF = 3'b010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'h0;
  logic clk_stable = 1'b1;
  logic mem_rst_n, cke, done;
  logic [2:0] cmd;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  int m_phase;
  int m_e;
  logic m_rst, m_cke, m_done;
  logic [2:0] m_cmd;
  logic prev_cke;

  always #5 clk = ~clk;

  ddr3_pwrup_seq #(.CYC_PER_US(CPU), .CKE_LOW_US(CLU), .CFG_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .clk_stable_i(clk_stable), .mem_rst_no(mem_rst_n), .mem_cke_o(cke),
    .cmd_o(cmd), .init_done_o(done)
  );

  function automatic bit valid_cfg(input logic [3:0] d);
    return (d[2:0] == 3'd3) && !d[3];
  endfunction

  function automatic logic [3:0] bad_cfg(input logic [3:0] d);
    logic [3:0] r = d;
    if (valid_cfg(r)) r[3] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R9/R2 mem_rst_no", int'(mem_rst_n), int'(m_rst));
    check("R5/R6 mem_cke_o", int'(cke), int'(m_cke));
    check("R7 cmd_o", int'(cmd), int'(m_cmd));
    check("R8 init_done_o", int'(done), int'(m_done));
  endtask

  task automatic step(input logic we, input logic [3:0] d, input logic st);
    @(negedge clk);
    cfg_we = we; cfg_wdata = d; clk_stable = st;
    prev_cke = cke;
    @(posedge clk);
    case (m_phase)
      0: begin m_rst = 1'b1; m_cmd = C_NOP; m_phase = 1; end
      1: if (we && valid_cfg(d)) begin m_phase = 2; m_e = 0; end
      2: begin
        m_e++;
        if (m_e >= N && st) begin m_cke = 1'b1; m_phase = 3; end
      end
      3: begin m_cmd = C_REF; m_phase = 4; end
      4: begin m_cmd = C_NOP; m_done = 1'b1; m_phase = 5; end
      default: ;
    endcase
    #2;
    compare_all();
    if (!prev_cke && cke && m_phase >= 2)
      check("R5 min CKE-low edges", int'(m_e >= N), 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cfg_we = 1'b0; clk_stable = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mem_rst_no", int'(mem_rst_n), 0);
    check("R1 mem_cke_o", int'(cke), 0);
    check("R1 cmd_o", int'(cmd), int'(C_DES));
    check("R1 init_done_o", int'(done), 0);
    m_phase = 0; m_e = 0; m_rst = 1'b0; m_cke = 1'b0; m_cmd = C_DES; m_done = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic idle(input int n, input logic st);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // directed: immediate valid write, clock stable throughout
    do_reset();
    step(1'b0, 4'h0, 1'b1);
    check("R2 mem_rst_no high", int'(mem_rst_n), 1);
    check("R2 cmd NOP", int'(cmd), int'(C_NOP));
    step(1'b1, 4'h3, 1'b1);
    idle(N + 4, 1'b1);
    check("R8 done after sequence", int'(done), 1);

    // directed: illegal writes are ignored, long wait in idle
    do_reset();
    step(1'b0, 4'h0, 1'b1);
    step(1'b1, 4'hB, 1'b1);   // type 3, disable set
    step(1'b1, 4'h2, 1'b1);   // type 2
    step(1'b1, 4'h7, 1'b1);   // type 7
    idle(N + 5, 1'b1);
    check("R4 cke low after bad writes", int'(cke), 0);
    check("R3 NOP held while waiting", int'(cmd), int'(C_NOP));
    step(1'b1, 4'h3, 1'b1);
    for (int i = 0; i < N - 1; i++) step(1'b1, 4'h3, 1'b1);  // R4 writes mid-sequence
    check("R5 cke still low one edge early", int'(cke), 0);
    step(1'b0, 4'h0, 1'b1);
    check("R5 cke high at exact edge", int'(cke), 1);
    idle(4, 1'b1);

    // directed: clock not stable at expiry
    do_reset();
    step(1'b0, 4'h0, 1'b0);
    step(1'b1, 4'h3, 1'b0);
    idle(N + 7, 1'b0);
    check("R6 cke held low without stable clock", int'(cke), 0);
    step(1'b0, 4'h0, 1'b1);
    check("R6 cke rises with stable clock", int'(cke), 1);
    idle(4, 1'b1);
    step(1'b1, 4'h3, 1'b1);  // R4 write after done
    check("R9 cke stays high", int'(cke), 1);

    // random runs
    for (int r = 0; r < 12; r++) begin
      do_reset();
      for (int i = 0; i < int'($urandom_range(1, 8)); i++)
        step(1'($urandom_range(0, 1)), bad_cfg(4'($urandom)), 1'($urandom_range(0, 1)));
      step(1'b1, 4'h3, 1'($urandom_range(0, 1)));
      for (int i = 0; i < N + 20; i++)
        step(1'($urandom_range(0, 1)), 4'($urandom), ($urandom_range(0, 3) != 0));
      idle(6, 1'b1);
      check("R8 done in random run", int'(done), 1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule